// File: doc/BRIEF.md
# Byte-wide I/O port with edge-flagged handshake lines

This block is one 8-bit general-purpose I/O port as seen by a processor through a two-address register interface. Each pin is individually an input or an output according to a direction register. The processor writes an output latch and reads back a merged view: input pins show their live level, output pins show the latched value. One address reaches either the output latch or the direction register, depending on a select bit held in the control register. The other address is the control register itself.

Two handshake inputs, called strobe A (`stb_a_in`) and strobe B (`stb_b_in`), pass through a synchroniser. An edge detector on each one compares the synchronised level with the level of the previous clock. Control bits choose the active edge of each strobe, enable its interrupt, and for strobe B choose whether the line is treated as an input at all. A matching edge sets a sticky flag, which the processor reads in the top two bits of the control register. A read of the output latch clears both flags. The `irq` output is high while any flag is set and enabled.

Each edge detector has a small arming state machine with two states. `ARM_FILL` is entered at reset. While in `ARM_FILL`, the detector counts clocks until the synchroniser and the previous-level register hold real samples. It then makes the transition `FILL_DONE` to `ARM_LIVE`. `ARM_LIVE` reports edges and holds until the next reset (`LIVE_HOLD`). The synchroniser flops reset to a high idle level, but that level is never compared as if it were a sample.

Top module: `pio_port`

## Requirements
- R1: After reset the direction register, the output latch and control bits 5..0 are zero. Both flags are clear, `pins_oe`, `pins_out` and `irq` are 0, and address 0 reads the direction register (0x00).
- R2: `pins_oe` equals the direction register. A 1 bit makes that pin an output and a 0 bit makes it an input.
- R3: `pins_out` equals output latch AND direction register. It is updated by a write to either register and holds when neither is written.
- R4: With select bit 2 set, a read of address 0 returns (pins_in AND NOT dir) OR (latch AND dir).
- R5: Control bit 2 steers address 0: 1 reaches the output latch and 0 reaches the direction register, for both reads and writes.
- R6: Address 1 reads {flagA, flagB, ctrl[5:0]}, with flag A at bit 7 and flag B at bit 6. A write to address 1 loads only bits 5..0, and flags are never set by a write.
- R7: Strobe A edges set flag A. Bit 1 picks the edge (0 falling, 1 rising), and the flag is set whether or not bit 0 (enable) is set. The flag becomes visible on the third rising clock edge after the input changes.
- R8: With bit 5 = 0 (strobe B is an input), strobe B edges set flag B, with bit 4 picking the edge (0 falling, 1 rising). With bit 5 = 1, strobe B edges are ignored.
- R9: The level a strobe holds when reset is released is not treated as an edge. Edges are reported only once the detector reaches `ARM_LIVE`, SYNC_STAGES+1 clocks after reset.
- R10: A read of address 0 with bit 2 set clears both flags. A read of the direction register or the control register does not. An edge in the same cycle as the clearing read leaves its flag set.
- R11: `irq` = (flagA AND bit0) OR (flagB AND bit3 AND NOT bit5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_sel_ctrl | input | 1 | 0 = latch/direction address, 1 = control address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, combinational from the address |
| pins_in | input | W | Pin levels |
| pins_out | output | W | Driven pin values |
| pins_oe | output | W | Per-pin output enable |
| stb_a_in | input | 1 | Handshake line A |
| stb_b_in | input | 1 | Handshake line B |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench holds both strobes low through reset. A detector that took the high reset level of its flops as a real sample would then flag a false falling edge, which matches the reset polarity. A data read is made on the exact clock where an edge lands, so a design that let the clear win would lose that event. Strobe B is toggled while in output mode, and again after switching modes with flag B set. This catches a design that still flags edges in output mode, or that keeps the interrupt asserted from a flag that no longer counts. Reads of the direction and control registers are checked not to clear flags, and a control write with bits 7..6 set is checked not to set them.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int CTRL_W = 8;

    // control register bit positions
    localparam int CB_A_EN   = 0;
    localparam int CB_A_RISE = 1;
    localparam int CB_DSEL   = 2;
    localparam int CB_B_EN   = 3;
    localparam int CB_B_RISE = 4;
    localparam int CB_B_OUT  = 5;
    localparam int FB_B      = 6;
    localparam int FB_A      = 7;

    localparam int CFG_W     = 6;
    localparam int NUM_STB   = 2;

    typedef enum logic [0:0] {
        ARM_FILL = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/pio_line_edge.sv
module pio_line_edge
    import pio_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_in,
    output edge_evt_t evt
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(SYNC_STAGES);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   level;
    arm_state_t             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q;

    assign level = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {SYNC_STAGES{IDLE_LEVEL}};
            prev_q  <= IDLE_LEVEL;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], line_in};
            prev_q  <= level;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARM_FILL)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // next state: FILL_DONE and LIVE_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_FILL: if (cnt_q == FILL_LAST) state_d = ARM_LIVE;
            ARM_LIVE: state_d = ARM_LIVE;
            default:  state_d = ARM_FILL;
        endcase
    end

    // outputs
    always_comb begin
        evt = '0;
        if (state_q == ARM_LIVE) begin
            evt.rise = level & ~prev_q;
            evt.fall = ~level & prev_q;
        end
    end

    a_r9_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ARM_LIVE |=> state_q == ARM_LIVE);

    a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ARM_FILL |-> cnt_q <= FILL_LAST);

endmodule

// File: rtl/pio_data_path.sv
module pio_data_path #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_latch,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins_in,
    output logic [W-1:0] pins_out,
    output logic [W-1:0] pins_oe,
    output logic [W-1:0] data_view,
    output logic [W-1:0] dir_view
);

    logic [W-1:0] dir_q;
    logic [W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
        end else begin
            if (wr_dir)   dir_q   <= wdata;
            if (wr_latch) latch_q <= wdata;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pins_out[b]  = latch_q[b] & dir_q[b];
        assign data_view[b] = dir_q[b] ? latch_q[b] : pins_in[b];
    end

    assign pins_oe  = dir_q;
    assign dir_view = dir_q;

    a_r3_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_latch && !wr_dir |=> $stable(pins_out));

    a_r2_oe_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pins_oe == $past(wdata));

endmodule

// File: rtl/pio_ctrl_flags.sv
module pio_ctrl_flags
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             flag_clr,
    input  logic             hit_a,
    input  logic             hit_b,
    output logic [CFG_W-1:0] cfg_q,
    output logic             flag_a_q,
    output logic             flag_b_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            flag_a_q <= 1'b0;
            flag_b_q <= 1'b0;
        end else begin
            if (cfg_wr) cfg_q <= cfg_wdata;
            if (hit_a)         flag_a_q <= 1'b1;
            else if (flag_clr) flag_a_q <= 1'b0;
            if (hit_b)         flag_b_q <= 1'b1;
            else if (flag_clr) flag_b_q <= 1'b0;
        end
    end

    a_r10_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !hit_a |=> !flag_a_q);

    a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> flag_a_q);

    a_r6_no_spurious_a: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_a_q && !hit_a |=> !flag_a_q);

    a_r6_no_spurious_b: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_b_q && !hit_b |=> !flag_b_q);

endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic         bus_sel_ctrl,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pins_in,
    output logic [W-1:0] pins_out,
    output logic [W-1:0] pins_oe,
    input  logic         stb_a_in,
    input  logic         stb_b_in,
    output logic         irq
);

    logic [CFG_W-1:0]   cfg;
    logic               flag_a, flag_b;
    logic               dsel, at_port;
    logic               wr_latch, wr_dir, cfg_wr, flag_clr;
    logic               hit_a, hit_b;
    logic [W-1:0]       data_view, dir_view;
    logic [CTRL_W-1:0]  ctrl_view;
    logic [NUM_STB-1:0] stb_vec;
    edge_evt_t          evt [NUM_STB];

    assign dsel     = cfg[CB_DSEL];
    assign at_port  = ~bus_sel_ctrl;
    assign wr_latch = bus_wr & at_port & dsel;
    assign wr_dir   = bus_wr & at_port & ~dsel;
    assign cfg_wr   = bus_wr & bus_sel_ctrl;
    assign flag_clr = bus_rd & at_port & dsel;

    assign stb_vec = {stb_b_in, stb_a_in};

    for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
        pio_line_edge #(
            .SYNC_STAGES (SYNC_STAGES),
            .IDLE_LEVEL  (1'b1)
        ) u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (stb_vec[g]),
            .evt     (evt[g])
        );
    end

    assign hit_a = cfg[CB_A_RISE] ? evt[0].rise : evt[0].fall;
    assign hit_b = ~cfg[CB_B_OUT] & (cfg[CB_B_RISE] ? evt[1].rise : evt[1].fall);

    pio_data_path #(.W(W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_latch  (wr_latch),
        .wr_dir    (wr_dir),
        .wdata     (bus_wdata),
        .pins_in   (pins_in),
        .pins_out  (pins_out),
        .pins_oe   (pins_oe),
        .data_view (data_view),
        .dir_view  (dir_view)
    );

    pio_ctrl_flags u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (bus_wdata[CFG_W-1:0]),
        .flag_clr  (flag_clr),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .cfg_q     (cfg),
        .flag_a_q  (flag_a),
        .flag_b_q  (flag_b)
    );

    assign ctrl_view = {flag_a, flag_b, cfg};

    always_comb begin
        if (bus_sel_ctrl) bus_rdata = W'(ctrl_view);
        else if (dsel)    bus_rdata = data_view;
        else              bus_rdata = dir_view;
    end

    assign irq = (flag_a & cfg[CB_A_EN]) |
                 (flag_b & cfg[CB_B_EN] & ~cfg[CB_B_OUT]);

    a_r11_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_a || flag_b));

    a_r8_out_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[CB_B_OUT] && !flag_b |=> !flag_b);

endmodule

// File: tb/sim_pio_port.sv
`timescale 1ns/1ps
module sim_pio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_ctrl = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, pins_in = '0, pins_out, pins_oe;
    logic       stb_a_in = 1'b0, stb_b_in = 1'b0, irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pio_port #(.W(8), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel_ctrl(bus_sel_ctrl), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe),
        .stb_a_in(stb_a_in), .stb_b_in(stb_b_in), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] m_dir = '0, m_lat = '0;
    logic [5:0] m_cfg = '0;
    bit m_fa = 0, m_fb = 0;
    bit qa[$], qb[$];

    function automatic bit hit(bit q[$], bit rising);
        bit cur, old;
        if (q.size() < 4) return 0;
        cur = q[q.size()-3];
        old = q[q.size()-4];
        return rising ? (!old && cur) : (old && !cur);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_lat = '0; m_cfg = '0; m_fa = 0; m_fb = 0;
            qa.delete(); qb.delete();
        end else begin
            bit ha, hb, clr;
            qa.push_back(stb_a_in);
            qb.push_back(stb_b_in);
            ha  = hit(qa, m_cfg[1]);
            hb  = !m_cfg[5] && hit(qb, m_cfg[4]);
            clr = bus_rd && !bus_sel_ctrl && m_cfg[2];
            m_fa = ha ? 1'b1 : (clr ? 1'b0 : m_fa);
            m_fb = hb ? 1'b1 : (clr ? 1'b0 : m_fb);
            if (bus_wr) begin
                if (bus_sel_ctrl)  m_cfg = bus_wdata[5:0];
                else if (m_cfg[2]) m_lat = bus_wdata;
                else               m_dir = bus_wdata;
            end
            if (qa.size() > 4) begin qa.pop_front(); qb.pop_front(); end
        end
    end

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [7:0] exp_rd;
            check8(pins_oe, m_dir, "R2 pins_oe");
            check8(pins_out, m_lat & m_dir, "R3 pins_out");
            check8({7'd0, irq}, {7'd0, (m_fa & m_cfg[0]) | (m_fb & m_cfg[3] & !m_cfg[5])}, "R11 irq");
            if (bus_sel_ctrl) begin
                exp_rd = {m_fa, m_fb, m_cfg};
                check8(bus_rdata, exp_rd, "R6 ctrl read");
            end else if (m_cfg[2]) begin
                exp_rd = (pins_in & ~m_dir) | (m_lat & m_dir);
                check8(bus_rdata, exp_rd, "R4 data read");
            end else begin
                check8(bus_rdata, m_dir, "R5 dir read");
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus_write(input bit sel, input logic [7:0] d);
        @(negedge clk); bus_sel_ctrl = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input bit sel);
        @(negedge clk); bus_sel_ctrl = sel; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic peek(input bit sel, input logic [7:0] exp, input string tag);
        @(negedge clk); bus_sel_ctrl = sel;
        #2;
        check8(bus_rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(6);
        peek(1, 8'h00, "R9 no flag from reset level");
        peek(0, 8'h00, "R1 dir after reset");
        check8({irq, pins_oe[0], pins_out[0]}, 8'h00, "R1 outputs after reset");

        bus_write(0, 8'hF0);               // direction (bit2 = 0)
        bus_write(1, 8'h04);               // select latch
        bus_write(0, 8'hA5);
        pins_in = 8'h3C;
        peek(0, 8'hAC, "R4 merged read");
        check8(pins_out, 8'hA0, "R3 latch and dir");
        check8(pins_oe, 8'hF0, "R2 oe");
        bus_write(1, 8'h00);
        peek(0, 8'hF0, "R5 dir readback");
        bus_write(0, 8'h0F);
        check8(pins_out, 8'h05, "R3 dir write updates out");
        bus_write(1, 8'h04);

        // strobe A, falling edge selected, enable off
        @(negedge clk); stb_a_in = 1'b1;
        idle(4);
        peek(1, 8'h04, "R7 rising ignored");
        @(negedge clk); stb_a_in = 1'b0;
        idle(4);
        peek(1, 8'h84, "R7 falling flags");
        check8({7'd0, irq}, 8'h00, "R11 irq off without enable");
        bus_write(1, 8'h05);
        check8({7'd0, irq}, 8'h01, "R11 irq with enable");
        bus_write(1, 8'h01);
        bus_read(0);                       // direction read
        peek(1, 8'h81, "R10 dir read keeps flag");
        bus_read(1);
        peek(1, 8'h81, "R10 ctrl read keeps flag");
        bus_write(1, 8'h05);
        bus_read(0);
        peek(1, 8'h05, "R10 data read clears");
        bus_write(1, 8'hC4);
        peek(1, 8'h04, "R6 flags not writable");

        // strobe B in output mode is ignored
        bus_write(1, 8'h3C);
        @(negedge clk); stb_b_in = 1'b1;
        idle(4);
        peek(1, 8'h3C, "R8 output mode ignores edge");
        @(negedge clk); stb_b_in = 1'b0;
        idle(4);
        bus_write(1, 8'h1C);               // input, rising, enabled
        @(negedge clk); stb_b_in = 1'b1;
        idle(4);
        peek(1, 8'h5C, "R8 rising flags B");
        check8({7'd0, irq}, 8'h01, "R11 irq from B");
        bus_write(1, 8'h3C);
        peek(1, 8'h7C, "R8 flag kept in output mode");
        check8({7'd0, irq}, 8'h00, "R11 B output masks irq");
        bus_read(0);
        peek(1, 8'h3C, "R10 clear B");

        // strobe A rising polarity
        bus_write(1, 8'h06);
        @(negedge clk); stb_a_in = 1'b1;
        idle(4);
        peek(1, 8'h86, "R7 rising flags A");
        bus_read(0);
        bus_write(1, 8'h04);

        // clearing read on the same clock as an edge
        @(negedge clk); stb_a_in = 1'b0;
        @(negedge clk);
        @(negedge clk); bus_sel_ctrl = 1'b0; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        peek(1, 8'h84, "R10 edge beats clear");

        // varied pins
        for (int i = 0; i < 8; i++) begin
            pins_in = 8'h11 * i[7:0];
            bus_write(0, 8'h5A ^ (8'h21 * i[7:0]));
            idle(1);
        end
        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule